// File: doc/BRIEF.md
# Zero-Extended Rotate Barrel Shifter

This block shifts a 32-bit operand logically left or right by 0 to 31 places and registers the result. The operand is placed in the low half of a 64-bit working word whose upper half is all zeros. That word is rotated right by a 6-bit amount through a short chain of radix-4 multiplexer stages. Each stage drops the upper bits that no later stage can reach, so the word narrows from 64 to 47 to 35 and then to 32 bits.

A right shift rotates by the shift amount itself. A left shift rotates by 64 minus the amount, which is the 6-bit two's complement of the amount. The zero half of the word fills the vacated positions in both directions, so no separate fill logic is needed. The block fits an execute stage: the amount comes from a 5-bit instruction field, the direction comes from decode, and the result is ready one clock after the inputs are presented.

Top module: `rot_barrel_shifter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes 0 at that edge.
- R2: `result` reflects the inputs present at the previous rising edge, a latency of exactly one cycle.
- R3: With `dir_left` = 0, `result` equals `operand` shifted right logically by `shamt`, and its top `shamt` bits are zero.
- R4: With `dir_left` = 1, `result` equals `operand` shifted left logically by `shamt`, and its low `shamt` bits are zero.
- R5: A `shamt` of 0 returns `operand` unchanged in both directions.
- R6: `dir_left` alone selects the direction (1 = left, 0 = right). The same operand and amount give the two different shifts.
- R7: A `shamt` of 31 keeps only one operand bit: bit 31 moved to bit 0 for a right shift, or bit 0 moved to bit 31 for a left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 32 | Value to shift |
| shamt | input | 5 | Shift distance, 0 to 31 |
| dir_left | input | 1 | 1 = shift left, 0 = shift right |
| result | output | 32 | Registered shifted value |

## Verification
The bench sweeps all 32 amounts in both directions over random and patterned operands and compares each result with an arithmetic shift computed in the bench.

Each corner case targets a specific fault:
- A zero amount on a left shift catches a negation that does not wrap to 0; such a design would rotate by 64 into the zero half and return 0.
- An amount of 31 exercises the deepest reach into the zero half; a stage that trims too many bits would lose the lone surviving bit.
- All-ones operands show any vacated bit that is filled from the wrong half of the word.
- A paired left/right check on one operand catches an inverted direction decode.

// File: rtl/rot_barrel_pkg.sv
package rot_barrel_pkg;

  typedef enum logic {
    DIR_RIGHT = 1'b0,
    DIR_LEFT  = 1'b1
  } shift_dir_e;

  // rotate step of stage g in a chain of n radix-4 stages (first stage is coarsest)
  function automatic int stage_step(input int g, input int n);
    return 1 << (2 * (n - 1 - g));
  endfunction

endpackage

// File: rtl/rot_amount_unit.sv
module rot_amount_unit #(
  parameter int SH_W  = 5,
  localparam int ROT_W = SH_W + 1
) (
  input  logic [SH_W-1:0]  shamt,
  input  logic             dir_left,
  output logic [ROT_W-1:0] rot_amt
);
  import rot_barrel_pkg::*;

  logic [ROT_W-1:0] amt_ext;

  assign amt_ext = {1'b0, shamt};

  // left shift = rotate right by the two's complement of the amount
  always_comb begin
    if (shift_dir_e'(dir_left) == DIR_LEFT) rot_amt = '0 - amt_ext;
    else                                    rot_amt = amt_ext;
  end

  // R4: a nonzero left amount always maps into the upper half of the rotate range
  always_comb begin
    if (dir_left && shamt != '0)
      assert (rot_amt[ROT_W-1]) else $error("p_left_upper_half_r4");
  end

endmodule

// File: rtl/rot_mux_stage.sv
module rot_mux_stage #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 47,
  parameter int STEP  = 16
) (
  input  logic [IN_W-1:0]  din,
  input  logic [1:0]       sel,
  output logic [OUT_W-1:0] dout
);
  logic [3:0][OUT_W-1:0] cand;

  for (genvar s = 0; s < 4; s++) begin : g_cand
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
      assign cand[s][i] = din[(i + s * STEP) % IN_W];
    end
  end

  always_comb dout = cand[sel];

  // a zero select passes the low bits straight through
  always_comb begin
    if (sel == 2'd0)
      assert (dout == din[OUT_W-1:0]) else $error("p_stage_pass_r5");
  end

endmodule

// File: rtl/rot_barrel_shifter.sv
module rot_barrel_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] operand,
  input  logic [SH_W-1:0]   shamt,
  input  logic              dir_left,
  output logic [DATA_W-1:0] result
);
  import rot_barrel_pkg::*;

  localparam int WORD_W  = 2 * DATA_W;
  localparam int ROT_W   = SH_W + 1;
  localparam int NUM_STG = ROT_W / 2;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [ROT_W-1:0]  rot_amt;
  logic [DATA_W-1:0] shifted;

  rot_amount_unit #(.SH_W(SH_W)) u_amt (
    .shamt    (shamt),
    .dir_left (dir_left),
    .rot_amt  (rot_amt)
  );

  for (genvar g = 0; g < NUM_STG; g++) begin : g_stg
    localparam int STEP  = stage_step(g, NUM_STG);
    localparam int IN_W  = (g == 0) ? WORD_W : DATA_W + 4 * STEP - 1;
    localparam int OUT_W = DATA_W + STEP - 1;

    logic [IN_W-1:0]  stg_in;
    logic [OUT_W-1:0] stg_out;

    if (g == 0) begin : g_first
      assign stg_in = {{(WORD_W - DATA_W){1'b0}}, operand};
    end else begin : g_next
      assign stg_in = g_stg[g-1].stg_out;
    end

    rot_mux_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .STEP(STEP)) u_stage (
      .din  (stg_in),
      .sel  (rot_amt[2*(NUM_STG-1-g) +: 2]),
      .dout (stg_out)
    );
  end

  assign shifted = g_stg[NUM_STG-1].stg_out;

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= shifted;
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> result == '0);

  p_zero_amount_r5: assert property (@(posedge clk) disable iff (rst)
    shamt == '0 |=> result == $past(operand));

  p_right_fill_r3: assert property (@(posedge clk) disable iff (rst)
    !dir_left |=> (result & ~(ONES >> $past(shamt))) == '0);

  p_left_fill_r4: assert property (@(posedge clk) disable iff (rst)
    dir_left |=> (result & ~(ONES << $past(shamt))) == '0);

endmodule

// File: tb/rot_barrel_shifter_bench.sv
module rot_barrel_shifter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand = '0;
  logic [4:0]  shamt = '0;
  logic        dir_left = 1'b0;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rot_barrel_shifter u_rot_barrel_shifter (
    .clk(clk), .rst(rst), .operand(operand), .shamt(shamt),
    .dir_left(dir_left), .result(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present inputs at a falling edge, check one rising edge later
  task automatic run_one(input logic [31:0] op, input int sh, input logic left);
    logic [31:0] exp;
    string tag;
    operand = op; shamt = 5'(sh); dir_left = left;
    exp = left ? (op << sh) : (op >> sh);
    if (sh == 0)       tag = "R5";
    else if (sh == 31) tag = "R7";
    else if (left)     tag = "R4";
    else               tag = "R3";
    @(negedge clk);
    check(tag, result, exp);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    operand = 32'hDEADBEEF; shamt = 5'd3;
    repeat (2) @(negedge clk);
    check("R1", result, 32'h0);
    rst = 1'b0;

    // R2: result follows exactly the inputs of the previous edge
    operand = 32'h1234_5678; shamt = 5'd8; dir_left = 1'b0;
    @(negedge clk);
    operand = 32'hFFFF_0000; shamt = 5'd4; dir_left = 1'b1;
    check("R2", result, 32'h0012_3456);
    @(negedge clk);
    check("R2", result, 32'hFFF0_0000);

    // R6: same operand and amount, direction alone decides
    run_one(32'h0000_0001, 4, 1'b1);
    operand = 32'h0000_0001; shamt = 5'd4; dir_left = 1'b0;
    @(negedge clk);
    check("R6", result, 32'h0);

    // R7 explicit extremes
    run_one(32'h8000_0000, 31, 1'b0);
    run_one(32'h7FFF_FFFF, 31, 1'b0);
    run_one(32'h0000_0001, 31, 1'b1);
    run_one(32'hFFFF_FFFE, 31, 1'b1);

    // sweep all amounts, both directions (R3, R4, R5, R7)
    for (int d = 0; d < 2; d++) begin
      for (int sh = 0; sh < 32; sh++) begin
        run_one(32'hFFFF_FFFF, sh, d[0]);
        run_one(32'h8000_0001, sh, d[0]);
        for (int k = 0; k < 8; k++) run_one($urandom, sh, d[0]);
      end
    end

    // R1 again: reset mid-run clears the register
    operand = 32'hFFFF_FFFF; shamt = 5'd0; rst = 1'b1;
    @(negedge clk);
    check("R1", result, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule